// File: doc/BRIEF.md
# Serial register-bus slave with coherent time capture

This block is a two-wire serial bus slave (I2C-compatible, up to 400 kHz) that fronts a 19-entry byte register file at addresses 00h to 12h. A master writes the device address, then a register pointer, then any number of data bytes. It can also issue a read, which returns bytes starting at the current pointer. The pointer advances after every data byte and wraps from the top address back to 00h.

The bus lines are oversampled by the fast system clock. SDA is driven as an open-drain output-enable, and SCL is never driven, so the slave does not stretch the clock. The first seven addresses hold the running time. The block receives these as a live vector and keeps a private copy of them. The copy is refreshed on every START and every time the pointer wraps to 00h. All reads of those addresses are served from the copy, so a multibyte read stays coherent while the time keeps running.

Writes leave the block through a single-byte write port. Bits that cannot be written at that address are cleared on this port. A write to address 00h also emits a pulse that restarts the sub-second divider. Reads of the other addresses use a combinational read port.

Top module: `rtc_bus_slave`

## Requirements
- R1: The slave acknowledges only the address byte D0h (write) or D1h (read), and it does so by pulling SDA low during the ninth clock. Any other address byte gets no acknowledge, and every later byte is ignored (no write, no acknowledge) until the next START.
- R2: In a write transfer, the first byte after the address is loaded into the pointer. Each following byte is acknowledged and written at the pointer, and the pointer then advances by one.
- R3: A data write is issued on the write port (one-cycle regWrEn with address and data) at the start of the slave's acknowledge for that byte. Unwritable bits are cleared according to these per-address masks: 00h 7Fh, 01h 7Fh, 02h 7Fh, 03h 07h, 04h 3Fh, 05h 9Fh, 06h to 0Eh FFh, 0Fh 8Bh, 10h FFh, 11h 00h, 12h 00h.
- R4: A read transfer returns the byte at the current pointer, MSB first, and changes SDA only after a falling SCL edge. Each byte the master acknowledges advances the pointer, and the next byte follows.
- R5: The pointer wraps from 12h to 00h during both read and write bursts. A pointer byte above 12h selects 00h.
- R6: Addresses 00h to 06h read from a copy of the live time vector (byte i at bits 8i+7 to 8i). The copy is taken at every START and repeated START, and at every wrap of the pointer to 00h. A change of the live vector after the copy does not alter the bytes returned.
- R7: A master NACK after a read byte ends the transfer. The slave leaves SDA released until the next START.
- R8: A STOP or START at any bit position aborts the current byte. A partly received data byte is never written.
- R9: Every write to address 00h produces a one-cycle secReset pulse in the same cycle as the write strobe. Writes to other addresses produce none.
- R10: The output enable rises only while SCL is low.
- R11: After reset, SDA is released, no write or secReset is issued, and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| timeLive | input | 56 | Live time bytes, byte i at bits 8i+7..8i |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrAddr | output | 5 | Write address |
| regWrData | output | 8 | Write data with unwritable bits cleared |
| secReset | output | 1 | Pulse on a write to address 00h |
| regRdAddr | output | 5 | Read address (current pointer) |
| regRdData | input | 8 | Register file byte at regRdAddr |

## Verification
Two functions can land in the same cycle. The pointer increment that follows the load of byte 12h also triggers the wrap refresh of the time copy, and that refresh must capture the live vector at that moment. The bench provokes this with a 21-byte read started by a repeated START. It changes the live vector after the third byte, then checks that bytes 03h to 06h still carry the values captured at the START and that the two bytes after the wrap carry the new values. A second case puts a write to 00h on the wrap of a write burst, so the wrapped write strobe and the secReset pulse occur together. The bench judges it by the stored byte and the pulse count.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;

  localparam logic [6:0] DEV_ADDR = 7'h68;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK0, ST_AACK1, ST_WBYTE,
    ST_WACK0, ST_WACK1, ST_RBYTE, ST_RACK, ST_RACKD
  } busState_t;

  typedef struct packed {
    logic       snap;      // refresh the time copy
    logic       ptrLoad;   // load pointer from wrByte
    logic       wrCommit;  // write wrByte at pointer, advance
    logic       rdLoad;    // byte taken for transmit, advance
    logic [7:0] wrByte;
  } busStrobe_t;

  function automatic logic [7:0] wrMaskOf(input logic [7:0] addr);
    logic [7:0] m;
    case (addr)
      8'h00, 8'h01, 8'h02: m = 8'h7F;
      8'h03:               m = 8'h07;
      8'h04:               m = 8'h3F;
      8'h05:               m = 8'h9F;
      8'h0F:               m = 8'h8B;
      8'h11, 8'h12:        m = 8'h00;
      default:             m = (addr <= 8'h10) ? 8'hFF : 8'h00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output busStrobe_t stb
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic [7:0] rxByte;
  logic [7:0] txShift;
  logic [7:0] nb;
  logic isRead, ptrPending;

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign nb       = {rxShift, sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe    <= '1;
      sdaPipe    <= '1;
      sclPrev    <= 1'b1;
      sdaPrev    <= 1'b1;
      state      <= ST_IDLE;
      bitCnt     <= '0;
      rxShift    <= '0;
      rxByte     <= '0;
      txShift    <= '0;
      isRead     <= 1'b0;
      ptrPending <= 1'b0;
      sdaOe      <= 1'b0;
      stb        <= '0;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      stb     <= '0;
      if (startDet) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        sdaOe    <= 1'b0;
        stb.snap <= 1'b1;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (sclRise) begin
            rxShift <= nb[6:0];
            bitCnt  <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (nb[7:1] == DEV_ADDR) begin
                isRead <= nb[0];
                state  <= ST_AACK0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK0: if (sclFall) begin
            sdaOe <= 1'b1;
            state <= ST_AACK1;
          end
          ST_AACK1: if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              stb.rdLoad <= 1'b1;
              sdaOe      <= ~rdByte[7];
              txShift    <= {rdByte[6:0], 1'b0};
              state      <= ST_RBYTE;
            end else begin
              sdaOe      <= 1'b0;
              ptrPending <= 1'b1;
              state      <= ST_WBYTE;
            end
          end
          ST_WBYTE: if (sclRise) begin
            rxShift <= nb[6:0];
            bitCnt  <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              rxByte <= nb;
              state  <= ST_WACK0;
            end
          end
          ST_WACK0: if (sclFall) begin
            sdaOe      <= 1'b1;
            stb.wrByte <= rxByte;
            if (ptrPending) stb.ptrLoad  <= 1'b1;
            else            stb.wrCommit <= 1'b1;
            ptrPending <= 1'b0;
            state      <= ST_WACK1;
          end
          ST_WACK1: if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= ST_WBYTE;
          end
          ST_RBYTE: if (sclFall) begin
            if (bitCnt == 3'd7) begin
              sdaOe <= 1'b0;
              state <= ST_RACK;
            end else begin
              sdaOe   <= ~txShift[7];
              txShift <= {txShift[6:0], 1'b0};
              bitCnt  <= bitCnt + 3'd1;
            end
          end
          ST_RACK: if (sclRise) begin
            state <= sdaS ? ST_IDLE : ST_RACKD;
          end
          ST_RACKD: if (sclFall) begin
            bitCnt     <= '0;
            stb.rdLoad <= 1'b1;
            sdaOe      <= ~rdByte[7];
            txShift    <= {rdByte[6:0], 1'b0};
            state      <= ST_RBYTE;
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  // R8
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaOe));

  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclRise && sdaS) |=> !sdaOe);

  // R8
  start_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && stb.snap));

endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_bus_pkg::*;
#(
  parameter int NUM_REGS   = 19,
  parameter int TIME_BYTES = 7,
  localparam int PTR_W     = $clog2(NUM_REGS),
  localparam int LAST      = NUM_REGS - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            stb,
  input  logic [TIME_BYTES*8-1:0] timeLive,
  input  logic [7:0]            regRdData,
  output logic [PTR_W-1:0]      regRdAddr,
  output logic [7:0]            rdByte,
  output logic                  regWrEn,
  output logic [PTR_W-1:0]      regWrAddr,
  output logic [7:0]            regWrData,
  output logic                  secReset
);

  logic [PTR_W-1:0] ptr, nextPtr;
  logic [7:0] shadow [TIME_BYTES];
  logic advance, wrapNow;

  assign nextPtr   = (ptr == PTR_W'(LAST)) ? '0 : ptr + 1'b1;
  assign advance   = stb.wrCommit | stb.rdLoad;
  assign wrapNow   = advance & (ptr == PTR_W'(LAST));
  assign regRdAddr = ptr;

  always_comb begin
    rdByte = regRdData;
    for (int i = 0; i < TIME_BYTES; i++)
      if (ptr == PTR_W'(i)) rdByte = shadow[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      secReset  <= 1'b0;
      for (int i = 0; i < TIME_BYTES; i++) shadow[i] <= '0;
    end else begin
      regWrEn  <= 1'b0;
      secReset <= 1'b0;
      if (stb.snap || wrapNow)
        for (int i = 0; i < TIME_BYTES; i++) shadow[i] <= timeLive[i*8 +: 8];
      if (stb.ptrLoad) begin
        ptr <= (stb.wrByte > 8'(LAST)) ? '0 : stb.wrByte[PTR_W-1:0];
      end else if (stb.wrCommit) begin
        regWrEn   <= 1'b1;
        regWrAddr <= ptr;
        regWrData <= stb.wrByte & wrMaskOf(8'(ptr));
        secReset  <= (ptr == '0);
        ptr       <= nextPtr;
      end else if (stb.rdLoad) begin
        ptr <= nextPtr;
      end
    end
  end

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(LAST));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> (ptr == '0));

  // R9
  sec_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    secReset |-> (regWrEn && regWrAddr == '0));

  // R3
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> ((regWrData & ~wrMaskOf(8'(regWrAddr))) == 8'h00));

  // R6
  snap_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.snap && !wrapNow) |=> $stable(shadow[0]));

endmodule

// File: rtl/rtc_bus_slave.sv
module rtc_bus_slave
  import rtc_bus_pkg::*;
#(
  parameter int NUM_REGS    = 19,
  parameter int TIME_BYTES  = 7,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaOe,
  input  logic [TIME_BYTES*8-1:0] timeLive,
  output logic                    regWrEn,
  output logic [PTR_W-1:0]        regWrAddr,
  output logic [7:0]              regWrData,
  output logic                    secReset,
  output logic [PTR_W-1:0]        regRdAddr,
  input  logic [7:0]              regRdData
);

  busStrobe_t stb;
  logic [7:0] rdByte;

  rtc_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .sdaOe(sdaOe), .stb(stb)
  );

  rtc_bus_regs #(.NUM_REGS(NUM_REGS), .TIME_BYTES(TIME_BYTES)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .timeLive(timeLive),
    .regRdData(regRdData), .regRdAddr(regRdAddr), .rdByte(rdByte),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .secReset(secReset)
  );

endmodule

// File: tb/tb_rtc_bus_slave.sv
module tb_rtc_bus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;
  localparam int NREG = 19;
  localparam int TBYTES = 7;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, regWrEn, secReset;
  logic [4:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;
  logic [TBYTES*8-1:0] timeLive = '0;
  wire sdaLine = sdaDrv & ~sdaOe;

  logic [7:0] regsM [0:31];
  int wrCnt = 0, secCnt = 0, oeBad = 0, cyc = 0;
  int checks = 0, failures = 0;
  logic prevOe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bus_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .timeLive(timeLive), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .secReset(secReset), .regRdAddr(regRdAddr),
    .regRdData(regRdData)
  );

  assign regRdData = regsM[regRdAddr];

  initial for (int i = 0; i < 32; i++) regsM[i] = 8'h00;

  always @(posedge clk) begin
    if (regWrEn) begin regsM[regWrAddr] <= regWrData; wrCnt <= wrCnt + 1; end
    if (secReset) secCnt <= secCnt + 1;
    if (sdaOe && !prevOe && sclDrv) oeBad <= oeBad + 1;
    prevOe <= sdaOe;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      failures = failures + 1;
      $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskB(input int a);
    if (a <= 2) return 8'h7F;
    if (a == 3) return 8'h07;
    if (a == 4) return 8'h3F;
    if (a == 5) return 8'h9F;
    if (a == 15) return 8'h8B;
    if (a == 17 || a == 18) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] tByte(input int seed, input int i);
    return 8'((seed * 16 + i) ^ 8'h80);
  endfunction

  task automatic setTime(input int seed);
    for (int i = 0; i < TBYTES; i++) timeLive[i*8 +: 8] = tByte(seed, i);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitClk(HALF);
    sclDrv = 1'b1; waitClk(HALF);
    sdaDrv = 1'b0; waitClk(HALF);
    sclDrv = 1'b0; waitClk(HALF);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitClk(HALF);
    sclDrv = 1'b1; waitClk(HALF);
    sdaDrv = 1'b1; waitClk(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; waitClk(HALF);
      sclDrv = 1'b1; waitClk(HALF);
      sclDrv = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    sdaDrv = 1'b1; waitClk(HALF);
    sclDrv = 1'b1; waitClk(HALF/2);
    ack = sdaLine; waitClk(HALF/2);
    sclDrv = 1'b0;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      sclDrv = 1'b1; waitClk(HALF/2);
      b[i] = sdaLine; waitClk(HALF/2);
      sclDrv = 1'b0;
    end
    sdaDrv = nack; waitClk(HALF);
    sclDrv = 1'b1; waitClk(HALF);
    sclDrv = 1'b0; sdaDrv = 1'b1;
  endtask

  logic ack;
  logic [7:0] rb;
  logic [7:0] pat;
  logic [7:0] expB;
  int wrBefore;

  initial begin
    setTime(0);
    waitClk(8);
    // R11 reset state
    chk(sdaOe == 1'b0 && regWrEn == 1'b0 && secReset == 1'b0, "R11 reset outputs", {sdaOe, regWrEn, secReset}, 0);
    rstN = 1'b1;
    waitClk(8);
    chk(sdaOe == 1'b0, "R11 idle after reset", sdaOe, 0);

    // R11 pointer 00h, R1 read address acked
    startCond();
    sendByte(8'hD1, ack);
    chk(ack == 1'b0, "R1 read address ack", ack, 0);
    recvByte(1'b1, rb);
    chk(rb == tByte(0, 0), "R11 first read at 00h", rb, tByte(0, 0));
    stopCond();

    // R2 R3 R9 sweep over all addresses
    for (int a = 0; a < NREG; a++) begin
      pat = 8'((a * 29 + 83) ^ (a[0] ? 8'hF0 : 8'h0F));
      startCond();
      sendByte(8'hD0, ack);
      chk(ack == 1'b0, "R1 write address ack", ack, 0);
      sendByte(8'(a), ack);
      sendByte(pat, ack);
      chk(ack == 1'b0, "R2 data byte ack", ack, 0);
      stopCond();
      chk(regsM[a] == (pat & maskB(a)), "R3 masked write", regsM[a], pat & maskB(a));
      if (a == 0) chk(secCnt == 1, "R9 pulse on 00h write", secCnt, 1);
    end
    chk(secCnt == 1, "R9 no pulse on other writes", secCnt, 1);
    chk(wrCnt == NREG, "R2 one write per data byte", wrCnt, NREG);

    // R5 write burst wrapping 12h -> 00h, R9 pulse with wrapped write
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h11, ack);
    sendByte(8'hEE, ack);
    sendByte(8'hDD, ack);
    sendByte(8'hBC, ack);
    stopCond();
    chk(regsM[0] == 8'h3C, "R5 write wrapped to 00h", regsM[0], 8'h3C);
    chk(secCnt == 2, "R9 pulse on wrapped write", secCnt, 2);

    // R4 R5 R6 coherent burst read with wrap
    setTime(1);
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h00, ack);
    startCond();
    sendByte(8'hD1, ack);
    chk(ack == 1'b0, "R1 ack after repeated START", ack, 0);
    for (int k = 0; k < NREG + 2; k++) begin
      recvByte(k == NREG + 1, rb);
      if (k == 2) setTime(2);
      if (k < TBYTES) expB = tByte(1, k);
      else if (k < NREG) expB = regsM[k];
      else expB = tByte(2, k - NREG);
      if (k < TBYTES) chk(rb == expB, "R6 byte from START copy", rb, expB);
      else if (k < NREG) chk(rb == expB, "R4 burst read byte", rb, expB);
      else chk(rb == expB, "R5 R6 byte after wrap copy", rb, expB);
    end
    // R7 released after NACK
    waitClk(4);
    chk(sdaOe == 1'b0, "R7 SDA released after NACK", sdaOe, 0);
    waitClk(HALF);
    chk(sdaOe == 1'b0, "R7 SDA stays released", sdaOe, 0);
    stopCond();

    // R4 pointer continued at 02h, fresh copy at new START
    setTime(3);
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b1, rb);
    chk(rb == tByte(3, 2), "R4 read resumes at pointer", rb, tByte(3, 2));
    stopCond();

    // R1 foreign address ignored until next START
    wrBefore = wrCnt;
    startCond();
    sendByte(8'hA0, ack);
    chk(ack == 1'b1, "R1 foreign address not acked", ack, 1);
    sendByte(8'h03, ack);
    chk(ack == 1'b1, "R1 later byte not acked", ack, 1);
    sendByte(8'h55, ack);
    stopCond();
    chk(wrCnt == wrBefore, "R1 no write after foreign address", wrCnt, wrBefore);

    // R8 STOP mid-byte aborts write
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h08, ack);
    sendBits(8'hF0, 4);
    stopCond();
    chk(wrCnt == wrBefore, "R8 partial byte not written", wrCnt, wrBefore);
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b1, rb);
    chk(rb == regsM[8], "R8 pointer kept, data unchanged", rb, regsM[8]);
    stopCond();

    // R5 pointer byte above range selects 00h
    setTime(4);
    startCond();
    sendByte(8'hD0, ack);
    sendByte(8'h1F, ack);
    startCond();
    sendByte(8'hD1, ack);
    recvByte(1'b1, rb);
    chk(rb == tByte(4, 0), "R5 out-of-range pointer to 00h", rb, tByte(4, 0));
    stopCond();

    waitClk(4);
    chk(oeBad == 0, "R10 enable rise while SCL high", oeBad, 0);
    summary();
  end
endmodule